// File: doc/BRIEF.md
# Page Attribute Resolver and Access Checker

This block sits beside the translation path of a memory management unit. It takes the memory-type and permission fields of one page descriptor and the mode and direction of the access. One cycle later it returns the inner and outer cacheability policy for the page and an allow/fault verdict with a fault class. A descriptor is offered on a lookup strobe, and each result comes back with its own valid strobe.

Software controls the block through a small register write port with a combinational read-back. The port holds two mode bits and two remap tables. With the remap bit clear, the memory-type fields decode directly. This is the legacy view that older operating systems expect. With it set, three descriptor bits index an eight-entry table that software programs, and the two upper TEX bits are left free for operating-system use. A second mode bit changes the lowest permission bit into an access flag that raises its own fault class.

Top module: `pgattr_resolver`

## Requirements
- R1: During and after reset, `res_valid`, `res_inner`, `res_outer` and `res_fault` are 0. The control word reads 0, and the inner table and the outer table each read 0x000040E0, which is the legacy decode packed as entry i at bits [2i+1:2i].
- R2: Address 0 holds the control word: bit 28 = remap enable, bit 29 = access-flag enable, all other bits read 0. Address 1 holds the inner table and address 2 the outer table, each in bits [15:0] with bits [31:16] reading 0. Address 3 reads 0 and ignores writes. `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle.
- R3: A register write affects lookups from the next cycle on. A lookup presented in the same cycle as the write uses the old value.
- R4: In legacy mode with TEX[2]=1, inner = {C,B} and outer = TEX[1:0]. Attribute codes are 00 non-cacheable, 01 write-back write-allocate, 10 write-through, 11 write-back no-allocate.
- R5: In legacy mode with TEX[2]=0, index {TEX[0],C,B} gives both inner and outer as follows: 2 maps to 10, 3 to 11, 7 to 01, and every other index to 00.
- R6: In remap mode, index i={TEX[0],C,B} gives inner = inner table bits [2i+1:2i] and outer = outer table bits [2i+1:2i].
- R7: In remap mode, TEX[2:1] has no effect on any output.
- R8: The permission code is P={APX,AP[1],AP[0]}. 000 allows no access. 001 allows privileged read/write and no user access. 010 allows privileged read/write and user read. 011 allows full access. 101 allows privileged read only. 100 and 110 fault on every access. A denied access gives fault 01.
- R9: P=111 allows reads in both modes and gives fault 01 on any write.
- R10: With access-flag enable set, AP[0]=0 gives fault 10 whatever else applies. Otherwise the permission decode uses P={APX,AP[1],1}.
- R11: With access-flag enable clear, fault 10 never occurs.
- R12: `res_valid` is high exactly one cycle after each cycle with `lk_valid` high. The result outputs change only in that cycle and hold at other times. Fault codes are 00 none, 01 permission, 10 access flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| lk_valid | input | 1 | Lookup strobe |
| lk_tex | input | 3 | Descriptor TEX field |
| lk_c | input | 1 | Descriptor C bit |
| lk_b | input | 1 | Descriptor B bit |
| lk_apx | input | 1 | Descriptor APX bit |
| lk_ap | input | 2 | Descriptor AP field |
| lk_priv | input | 1 | Access made in privileged mode |
| lk_write | input | 1 | Access is a write |
| res_valid | output | 1 | Result strobe |
| res_inner | output | 2 | Resolved inner cacheability |
| res_outer | output | 2 | Resolved outer cacheability |
| res_fault | output | 2 | Fault class |

## Verification
The bench places different table values at each remap index and changes only TEX[2:1] between pairs of lookups. A design that still decoded those bits, or that took its index from the wrong field, returns a different attribute. It starts a lookup in the same cycle as a table write, which exposes a design that forwards the new value too early. It offers a flag-clear descriptor whose permission code would also deny access, so a wrong fault priority shows up as code 01 instead of 10. It also uses the reserved codes with access-flag enable off, where a flag fault would be wrong. For the read-only-everywhere code, a design that treats the code as reserved fails the read checks, and one that ignores the write direction fails the write checks.

// File: rtl/pgattr_pkg.sv
package pgattr_pkg;

  localparam int unsigned IDX_W   = 3;
  localparam int unsigned ATTR_W  = 2;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TBL_W   = ATTR_W * ENTRIES;

  localparam int unsigned CTRL_REMAP_BIT = 28;
  localparam int unsigned CTRL_AF_BIT    = 29;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_PERM   = 2'b01,
    FLT_ACCESS = 2'b10
  } fault_e;

  // Legacy attribute for TEX[2]=0, indexed by {TEX[0],C,B}
  function automatic logic [ATTR_W-1:0] legacy_low(input logic [IDX_W-1:0] idx);
    logic [ATTR_W-1:0] a;
    case (idx)
      3'd2:    a = 2'b10;
      3'd3:    a = 2'b11;
      3'd7:    a = 2'b01;
      default: a = 2'b00;
    endcase
    return a;
  endfunction

  function automatic logic [TBL_W-1:0] legacy_table();
    logic [TBL_W-1:0] t;
    t = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      t[i*ATTR_W +: ATTR_W] = legacy_low(IDX_W'(i));
    end
    return t;
  endfunction

endpackage

// File: rtl/pgattr_regs.sv
module pgattr_regs
  import pgattr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              remap_en,
  output logic              af_en,
  output logic [TBL_W-1:0]  inner_tbl,
  output logic [TBL_W-1:0]  outer_tbl
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_INNER = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OUTER = ADDR_W'(2);
  localparam logic [TBL_W-1:0]  TBL_RST = legacy_table();

  logic             remap_q, remap_d;
  logic             af_q, af_d;
  logic [TBL_W-1:0] inner_q, inner_d;
  logic [TBL_W-1:0] outer_q, outer_d;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    remap_d = remap_q;
    af_d    = af_q;
    inner_d = inner_q;
    outer_d = outer_q;
    if (we) begin
      case (addr)
        A_CTRL: begin
          remap_d = wdata[CTRL_REMAP_BIT];
          af_d    = wdata[CTRL_AF_BIT];
        end
        A_INNER: inner_d = wdata[TBL_W-1:0];
        A_OUTER: outer_d = wdata[TBL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
      af_q    <= 1'b0;
      inner_q <= TBL_RST;
      outer_q <= TBL_RST;
    end else begin
      remap_q <= remap_d;
      af_q    <= af_d;
      inner_q <= inner_d;
      outer_q <= outer_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTRL_REMAP_BIT] = remap_q;
        rdata[CTRL_AF_BIT]    = af_q;
      end
      A_INNER: rdata[TBL_W-1:0] = inner_q;
      A_OUTER: rdata[TBL_W-1:0] = outer_q;
      default: ;
    endcase
  end

  assign remap_en  = remap_q;
  assign af_en     = af_q;
  assign inner_tbl = inner_q;
  assign outer_tbl = outer_q;

  AST_INNER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_INNER) |=> inner_tbl == $past(wdata[TBL_W-1:0])); // R3
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CTRL) |=> remap_en == $past(wdata[CTRL_REMAP_BIT])); // R2

endmodule

// File: rtl/pgattr_decode.sv
module pgattr_decode
  import pgattr_pkg::*;
(
  input  logic              remap_en,
  input  logic [2:0]        tex,
  input  logic              c,
  input  logic              b,
  input  logic [TBL_W-1:0]  inner_tbl,
  input  logic [TBL_W-1:0]  outer_tbl,
  output logic [ATTR_W-1:0] inner,
  output logic [ATTR_W-1:0] outer
);

  logic [ATTR_W-1:0] in_ent  [ENTRIES];
  logic [ATTR_W-1:0] out_ent [ENTRIES];
  logic [IDX_W-1:0]  idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign in_ent[g]  = inner_tbl[g*ATTR_W +: ATTR_W];
    assign out_ent[g] = outer_tbl[g*ATTR_W +: ATTR_W];
  end

  assign idx = {tex[0], c, b};

  always_comb begin
    if (remap_en) begin
      inner = in_ent[idx];
      outer = out_ent[idx];
    end else if (tex[2]) begin
      inner = {c, b};
      outer = tex[1:0];
    end else begin
      inner = legacy_low(idx);
      outer = legacy_low(idx);
    end
  end

endmodule

// File: rtl/pgattr_perm.sv
module pgattr_perm
  import pgattr_pkg::*;
(
  input  logic       af_en,
  input  logic       apx,
  input  logic [1:0] ap,
  input  logic       priv,
  input  logic       write,
  output fault_e     fault
);

  logic [2:0] code;
  logic       allow;

  assign code = {apx, ap[1], (af_en ? 1'b1 : ap[0])};

  always_comb begin
    case (code)
      3'b001:  allow = priv;
      3'b010:  allow = priv | ~write;
      3'b011:  allow = 1'b1;
      3'b101:  allow = priv & ~write;
      3'b111:  allow = ~write;
      default: allow = 1'b0;
    endcase
  end

  always_comb begin
    if (af_en && !ap[0])  fault = FLT_ACCESS;
    else if (!allow)      fault = FLT_PERM;
    else                  fault = FLT_NONE;
  end

endmodule

// File: rtl/pgattr_resolver.sv
module pgattr_resolver
  import pgattr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        lk_valid,
  input  logic [2:0]  lk_tex,
  input  logic        lk_c,
  input  logic        lk_b,
  input  logic        lk_apx,
  input  logic [1:0]  lk_ap,
  input  logic        lk_priv,
  input  logic        lk_write,
  output logic        res_valid,
  output logic [1:0]  res_inner,
  output logic [1:0]  res_outer,
  output logic [1:0]  res_fault
);

  logic              remap_en, af_en;
  logic [TBL_W-1:0]  inner_tbl, outer_tbl;
  logic [ATTR_W-1:0] inner_c, outer_c;
  fault_e            fault_c;

  logic              valid_q, valid_d;
  logic [ATTR_W-1:0] inner_q, inner_d;
  logic [ATTR_W-1:0] outer_q, outer_d;
  logic [1:0]        fault_q, fault_d;

  pgattr_regs #(.DATA_W(32), .ADDR_W(2)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .remap_en  (remap_en),
    .af_en     (af_en),
    .inner_tbl (inner_tbl),
    .outer_tbl (outer_tbl)
  );

  pgattr_decode u_decode (
    .remap_en  (remap_en),
    .tex       (lk_tex),
    .c         (lk_c),
    .b         (lk_b),
    .inner_tbl (inner_tbl),
    .outer_tbl (outer_tbl),
    .inner     (inner_c),
    .outer     (outer_c)
  );

  pgattr_perm u_perm (
    .af_en (af_en),
    .apx   (lk_apx),
    .ap    (lk_ap),
    .priv  (lk_priv),
    .write (lk_write),
    .fault (fault_c)
  );

  always_comb begin
    valid_d = lk_valid;
    inner_d = inner_q;
    outer_d = outer_q;
    fault_d = fault_q;
    if (lk_valid) begin
      inner_d = inner_c;
      outer_d = outer_c;
      fault_d = fault_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      inner_q <= '0;
      outer_q <= '0;
      fault_q <= '0;
    end else begin
      valid_q <= valid_d;
      inner_q <= inner_d;
      outer_q <= outer_d;
      fault_q <= fault_d;
    end
  end

  assign res_valid = valid_q;
  assign res_inner = inner_q;
  assign res_outer = outer_q;
  assign res_fault = fault_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && $stable(res_fault) && $stable(res_inner))); // R12
  AST_FLAG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && cfg_rdata[CTRL_AF_BIT] && cfg_addr == 2'd0 && !lk_ap[0])
      |=> res_fault == 2'b10); // R10
  AST_NO_FLAG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !af_en) |=> res_fault != 2'b10); // R11
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write && lk_apx && lk_ap == 2'b11) |=> res_fault == 2'b01); // R9

endmodule

// File: tb/tb_pgattr_resolver.sv
module tb_pgattr_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  // {ctrl{af,remap}, tex, c, b, apx, ap, priv, write, inner, outer, fault}
  localparam logic [17:0] VECS [NVEC] = '{
    18'b00_000_00_011_01_00_00_00,
    18'b00_000_10_001_11_10_10_00,
    18'b00_000_11_001_00_11_11_01,
    18'b00_001_11_010_00_01_01_00,
    18'b00_001_00_010_01_00_00_01,
    18'b00_101_10_101_10_10_01_00,
    18'b00_110_01_101_11_01_10_01,
    18'b00_111_11_000_10_11_11_01,
    18'b00_100_00_100_10_00_00_01,
    18'b00_010_11_110_00_11_11_01,
    18'b00_000_00_111_10_00_00_00,
    18'b00_000_00_111_01_00_00_01,
    18'b00_000_00_111_11_00_00_01,
    18'b01_000_00_011_00_11_11_00,
    18'b01_110_00_011_00_11_11_00,
    18'b01_001_10_011_00_01_00_00,
    18'b01_111_10_011_00_01_00_00,
    18'b01_100_11_011_00_00_11_00,
    18'b01_011_01_011_00_10_00_00,
    18'b10_000_00_000_10_00_00_10,
    18'b10_000_00_001_00_00_00_01,
    18'b10_000_00_011_01_00_00_00,
    18'b10_000_00_010_10_00_00_10,
    18'b10_000_00_101_11_00_00_01,
    18'b10_000_00_111_10_00_00_00,
    18'b10_000_00_110_00_00_00_10,
    18'b11_110_01_011_00_10_11_00
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lk_valid;
  logic [2:0]  lk_tex;
  logic        lk_c, lk_b, lk_apx, lk_priv, lk_write;
  logic [1:0]  lk_ap;
  logic        res_valid;
  logic [1:0]  res_inner, res_outer, res_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgattr_resolver dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_tex(lk_tex), .lk_c(lk_c), .lk_b(lk_b),
    .lk_apx(lk_apx), .lk_ap(lk_ap), .lk_priv(lk_priv), .lk_write(lk_write),
    .res_valid(res_valid), .res_inner(res_inner), .res_outer(res_outer), .res_fault(res_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic cfg_read(input string req, input logic [1:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
    cfg_addr = 2'd0;
  endtask

  task automatic set_lookup(input logic [2:0] tex, input logic c, input logic b,
                            input logic [2:0] perm, input logic priv, input logic wr);
    lk_valid = 1'b1; lk_tex = tex; lk_c = c; lk_b = b;
    lk_apx = perm[2]; lk_ap = perm[1:0]; lk_priv = priv; lk_write = wr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur_ctrl;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    lk_valid = 1'b0; lk_tex = '0; lk_c = 0; lk_b = 0; lk_apx = 0; lk_ap = '0;
    lk_priv = 0; lk_write = 0;
    repeat (3) @(negedge clk);

    // R1: state during reset and just after
    check("R1 valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 fault", 32'(res_fault), 32'd0);
    check("R1 inner out", 32'(res_inner), 32'd0);
    cfg_read("R1 ctrl", 2'd0, 32'h0);
    cfg_read("R1 inner table", 2'd1, 32'h0000_40E0);
    cfg_read("R1 outer table", 2'd2, 32'h0000_40E0);

    // R2: register map and masking
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_read("R2 ctrl mask", 2'd0, 32'h3000_0000);
    cfg_write(2'd1, 32'hABCD_1B1B);
    cfg_read("R2 inner mask", 2'd1, 32'h0000_1B1B);
    cfg_write(2'd2, 32'h0000_00FF);
    cfg_read("R2 outer", 2'd2, 32'h0000_00FF);
    cfg_write(2'd3, 32'hFFFF_FFFF);
    cfg_read("R2 addr3 zero", 2'd3, 32'h0);
    cfg_read("R2 addr3 no side effect", 2'd1, 32'h0000_1B1B);
    cfg_write(2'd0, 32'h0);
    cur_ctrl = 2'b00;

    // Vector table: R4 R5 legacy, R6 R7 remap, R8 R9 R10 R11 permissions
    for (int i = 0; i < NVEC; i++) begin
      logic [17:0] v;
      v = VECS[i];
      if (v[17:16] != cur_ctrl) begin
        cfg_write(2'd0, {2'b00, v[17], v[16], 28'h0});
        cur_ctrl = v[17:16];
      end
      @(negedge clk);
      set_lookup(v[15:13], v[12], v[11], v[10:8], v[7], v[6]);
      @(negedge clk);
      lk_valid = 1'b0;
      check($sformatf("R12 valid vec %0d", i), 32'(res_valid), 32'd1);
      check($sformatf("%s inner vec %0d", v[16] ? "R6 R7" : "R4 R5", i),
            32'(res_inner), 32'(v[5:4]));
      check($sformatf("%s outer vec %0d", v[16] ? "R6 R7" : "R4 R5", i),
            32'(res_outer), 32'(v[3:2]));
      check($sformatf("R8 R9 R10 R11 fault vec %0d", i), 32'(res_fault), 32'(v[1:0]));
    end

    // R3: a lookup in the same cycle as a write sees the old table
    cfg_write(2'd0, 32'h1000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0000_FFFF;
    set_lookup(3'b000, 1'b0, 1'b1, 3'b011, 1'b1, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd0;
    check("R3 same-cycle old value", 32'(res_inner), 32'd2);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R3 next-cycle new value", 32'(res_inner), 32'd3);

    // R12: outputs hold with no lookup, valid is a single pulse
    lk_tex = 3'b111; lk_c = 1'b0; lk_b = 1'b0; lk_apx = 1'b0; lk_ap = 2'b00;
    @(negedge clk);
    check("R12 valid pulse ends", 32'(res_valid), 32'd0);
    @(negedge clk);
    check("R12 inner holds", 32'(res_inner), 32'd3);
    check("R12 fault holds", 32'(res_fault), 32'd0);

    // R1: reset in mid-run restores defaults
    rst_n = 1'b0;
    #1;
    check("R1 mid-run valid", 32'(res_valid), 32'd0);
    check("R1 mid-run inner out", 32'(res_inner), 32'd0);
    cfg_read("R1 mid-run ctrl", 2'd0, 32'h0);
    cfg_read("R1 mid-run inner table", 2'd1, 32'h0000_40E0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule